// File: doc/BRIEF.md
# Electron-Arrival Counting Dose Controller

This block sits between a fast detector sample stream and the beam blanker of an exposure tool. It estimates the dose that the current pixel has received as a number of electron arrivals. Pulses in the detector signal are found with a two-level hysteresis detector. From those pulses the block builds two estimates side by side. The first adds one per detected pulse. The second sums the area of each pulse and multiplies it by a host-supplied reciprocal of the mean single-electron area. The fractional part of that product carries over to later pulses.

A host mode setting picks which estimate gates the beam: the pulse estimate, the area estimate, or whichever of the two reaches the programmed target first. The exposure tool's own blank signal marks pixel boundaries. While the tool holds the beam blanked, both estimates and all pulse state are held at zero, so every pixel starts fresh when the tool releases the beam. The output blank is the tool's blank combined by OR with a dose-reached condition. That condition rises in the same cycle the selected estimate reaches the target.

Samples arrive on a valid/ready stream, one per clock. The block never applies back-pressure: ready is held high at all times, and a sample is consumed in every cycle that valid is high. A producer may leave gaps by dropping valid; cycles without valid change nothing.

Top module: `ecount_dose_ctrl`

## Requirements
- R1: `s_ready` is high in every cycle, including during reset. A sample is consumed in each cycle in which `s_valid` is high.
- R2: While no pulse is open, a consumed sample strictly greater than `cfg_thr_hi` opens a pulse. While a pulse is open, a consumed sample strictly less than `cfg_thr_lo` closes it. Any other sample leaves the open/closed state unchanged; this includes a sample equal to either threshold.
- R3: `est_pulses` rises by exactly one on the clock edge at which a pulse-opening sample is consumed. It saturates at its all-ones value.
- R4: The area of a pulse is the sum of all samples from the opening sample up to and including the last sample before the closing one. On the edge where the closing sample is consumed, `est_electrons` rises by floor((F + A*`cfg_recip`) / 2^FRAC_W). Here A is the area and F is the carried remainder. `cfg_recip` holds FRAC_W fractional bits. `est_electrons` saturates at all-ones.
- R5: The remainder (F + A*`cfg_recip`) mod 2^FRAC_W is kept and added to the next closing pulse of the same pixel.
- R6: `cfg_mode` selects the dose estimate: 2'b00 uses `est_pulses`, 2'b01 uses `est_electrons`, and 2'b10 or 2'b11 uses whichever of the two reaches the target first.
- R7: `beam_blank` = `tool_blank` OR (selected estimate >= `cfg_target`). It is not registered after the estimates, so it rises in the same cycle the estimate reaches the target. A target of zero keeps the beam blanked.
- R8: In any cycle in which `tool_blank` is high, samples are discarded. On the following edge both estimates, the remainder and any open pulse are cleared. A pulse cut by the tool's blank is never counted.
- R9: After the target has been reached, counting goes on: a pulse that is open or that starts afterwards is still counted when it opens or closes.
- R10: A cycle with `s_valid` low changes neither estimate nor the pulse state.
- R11: While `rst_n` is low, both estimates are zero and no pulse is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready, always high |
| s_data | input | SAMPLE_W | Unsigned detector sample |
| tool_blank | input | 1 | Blank request from the exposure tool; high marks the gap between pixels |
| cfg_mode | input | 2 | Estimate select (see R6) |
| cfg_thr_hi | input | SAMPLE_W | Pulse-open threshold |
| cfg_thr_lo | input | SAMPLE_W | Pulse-close threshold |
| cfg_recip | input | RECIP_W | Reciprocal of single-electron area, FRAC_W fractional bits |
| cfg_target | input | COUNT_W | Electron target for one pixel |
| beam_blank | output | 1 | Blank drive to the beam blanker |
| est_pulses | output | COUNT_W | Pulse-count estimate for the current pixel |
| est_electrons | output | COUNT_W | Area-based electron estimate for the current pixel |

## Verification
The bench builds the block with 8-bit samples, a 12-bit area, an 8-bit reciprocal holding 8 fractional bits, and 6-bit counts. With these widths the remainder carry between pulses shows up in small integers that can be worked out by hand. The 6-bit count lets a run of 70 short pulses drive both estimates into saturation within a few hundred cycles. The small thresholds place the equal-to-threshold samples and the hysteresis band at plain values. This lets the bench check each mode switch, the blank cut in the middle of a pulse, and the zero target directly at the ports.

// File: rtl/ecd_pkg.sv
package ecd_pkg;

  typedef enum logic [1:0] {
    MODE_PULSE  = 2'b00,
    MODE_AREA   = 2'b01,
    MODE_FIRST  = 2'b10,
    MODE_FIRST2 = 2'b11
  } ecd_mode_e;

endpackage

// File: rtl/ecd_pulse_track.sv
module ecd_pulse_track #(
  parameter int SAMPLE_W = 14,
  parameter int AREA_W   = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                take_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] thr_hi_i,
  input  logic [SAMPLE_W-1:0] thr_lo_i,
  output logic                open_o,
  output logic                close_o,
  output logic [AREA_W-1:0]   area_o
);

  localparam int SUM_W = AREA_W + 1;
  localparam logic [AREA_W-1:0] AREA_MAX = '1;

  logic              in_pulse_q;
  logic [AREA_W-1:0] area_q;
  logic [SUM_W-1:0]  area_sum;
  logic [AREA_W-1:0] area_next;

  // hysteresis: open strictly above the high level, close strictly below the low level
  assign open_o  = take_i & ~in_pulse_q & (sample_i > thr_hi_i);
  assign close_o = take_i &  in_pulse_q & (sample_i < thr_lo_i);
  assign area_o  = area_q;

  always_comb begin
    area_sum  = SUM_W'(area_q) + SUM_W'(sample_i);
    area_next = area_sum[SUM_W-1] ? AREA_MAX : area_sum[AREA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pulse_q <= 1'b0;
      area_q     <= '0;
    end else if (clr_i) begin
      in_pulse_q <= 1'b0;
      area_q     <= '0;
    end else if (open_o) begin
      in_pulse_q <= 1'b1;
      area_q     <= AREA_W'(sample_i);
    end else if (close_o) begin
      in_pulse_q <= 1'b0;
      area_q     <= '0;
    end else if (take_i && in_pulse_q) begin
      area_q     <= area_next;
    end
  end

endmodule

// File: rtl/ecd_pulse_counter.sv
module ecd_pulse_counter #(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               inc_i,
  output logic [COUNT_W-1:0] count_o
);

  localparam logic [COUNT_W-1:0] CNT_MAX = '1;

  logic [COUNT_W-1:0] cnt_q;

  assign count_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/ecd_area_scaler.sv
module ecd_area_scaler #(
  parameter int AREA_W  = 24,
  parameter int RECIP_W = 16,
  parameter int FRAC_W  = 16,
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               fire_i,
  input  logic [AREA_W-1:0]  area_i,
  input  logic [RECIP_W-1:0] recip_i,
  output logic [COUNT_W-1:0] count_o
);

  localparam int PROD_W = AREA_W + RECIP_W;
  localparam int ACC_W  = PROD_W + 1;
  localparam int INT_W  = ACC_W - FRAC_W;
  localparam int SUM_W  = ((INT_W > COUNT_W) ? INT_W : COUNT_W) + 1;
  localparam logic [COUNT_W-1:0] CNT_MAX = '1;

  logic [COUNT_W-1:0] cnt_q;
  logic [FRAC_W-1:0]  frac_q;
  logic [PROD_W-1:0]  prod;
  logic [ACC_W-1:0]   acc;
  logic [INT_W-1:0]   whole;
  logic [SUM_W-1:0]   sum;
  logic [COUNT_W-1:0] cnt_next;

  always_comb begin
    prod     = PROD_W'(area_i) * PROD_W'(recip_i);
    acc      = ACC_W'(prod) + ACC_W'(frac_q);
    whole    = acc[ACC_W-1:FRAC_W];
    sum      = SUM_W'(cnt_q) + SUM_W'(whole);
    cnt_next = (sum > SUM_W'(CNT_MAX)) ? CNT_MAX : sum[COUNT_W-1:0];
  end

  assign count_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      frac_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      frac_q <= '0;
    end else if (fire_i) begin
      cnt_q  <= cnt_next;
      frac_q <= acc[FRAC_W-1:0];
    end
  end

endmodule

// File: rtl/ecount_dose_ctrl.sv
module ecount_dose_ctrl
  import ecd_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int AREA_W   = 24,
  parameter int RECIP_W  = 16,
  parameter int FRAC_W   = 16,
  parameter int COUNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic                tool_blank,
  input  logic [1:0]          cfg_mode,
  input  logic [SAMPLE_W-1:0] cfg_thr_hi,
  input  logic [SAMPLE_W-1:0] cfg_thr_lo,
  input  logic [RECIP_W-1:0]  cfg_recip,
  input  logic [COUNT_W-1:0]  cfg_target,
  output logic                beam_blank,
  output logic [COUNT_W-1:0]  est_pulses,
  output logic [COUNT_W-1:0]  est_electrons
);

  logic              take;
  logic              p_open;
  logic              p_close;
  logic [AREA_W-1:0] p_area;
  logic              hit_pulse;
  logic              hit_area;
  logic              dose_hit;
  ecd_mode_e         mode;

  assign s_ready = 1'b1;
  assign take    = s_valid & ~tool_blank;
  assign mode    = ecd_mode_e'(cfg_mode);

  ecd_pulse_track #(
    .SAMPLE_W (SAMPLE_W),
    .AREA_W   (AREA_W)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (tool_blank),
    .take_i   (take),
    .sample_i (s_data),
    .thr_hi_i (cfg_thr_hi),
    .thr_lo_i (cfg_thr_lo),
    .open_o   (p_open),
    .close_o  (p_close),
    .area_o   (p_area)
  );

  ecd_pulse_counter #(
    .COUNT_W (COUNT_W)
  ) u_pcount (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (tool_blank),
    .inc_i   (p_open),
    .count_o (est_pulses)
  );

  ecd_area_scaler #(
    .AREA_W  (AREA_W),
    .RECIP_W (RECIP_W),
    .FRAC_W  (FRAC_W),
    .COUNT_W (COUNT_W)
  ) u_ascale (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (tool_blank),
    .fire_i  (p_close),
    .area_i  (p_area),
    .recip_i (cfg_recip),
    .count_o (est_electrons)
  );

  always_comb begin
    hit_pulse = (est_pulses >= cfg_target);
    hit_area  = (est_electrons >= cfg_target);
    unique case (mode)
      MODE_PULSE: dose_hit = hit_pulse;
      MODE_AREA:  dose_hit = hit_area;
      default:    dose_hit = hit_pulse | hit_area;
    endcase
  end

  assign beam_blank = tool_blank | dose_hit;

endmodule

// File: rtl/ecount_dose_ctrl_chk.sv
module ecount_dose_ctrl_chk #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               s_valid,
  input logic               s_ready,
  input logic               tool_blank,
  input logic [1:0]         cfg_mode,
  input logic [COUNT_W-1:0] cfg_target,
  input logic               beam_blank,
  input logic [COUNT_W-1:0] est_pulses,
  input logic [COUNT_W-1:0] est_electrons
);

  // R1: never back-pressures
  a_r1_ready_high: assert property (@(posedge clk) s_ready);

  // R7: the tool's blank always reaches the blanker
  a_r7_tool_blank_passes: assert property (@(posedge clk) disable iff (!rst_n)
    tool_blank |-> beam_blank);

  // R7: once dose is reached inside a pixel, blanking holds unless config moves
  a_r7_dose_blank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_blank && !tool_blank) |=>
      (beam_blank || !$stable(cfg_target) || !$stable(cfg_mode)));

  // R8: a tool blank cycle clears both estimates
  a_r8_blank_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tool_blank |=> (est_pulses == '0 && est_electrons == '0));

  // R3: the pulse estimate moves by zero or one per cycle inside a pixel
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !tool_blank |=> (est_pulses == $past(est_pulses) ||
                     est_pulses == $past(est_pulses) + 1'b1));

  // R4: the area estimate never falls inside a pixel
  a_r4_electrons_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !tool_blank |=> (est_electrons >= $past(est_electrons)));

  // R10: no valid sample, no change
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_valid && !tool_blank) |=> ($stable(est_pulses) && $stable(est_electrons)));

endmodule

bind ecount_dose_ctrl ecount_dose_ctrl_chk #(
  .COUNT_W (COUNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .s_valid       (s_valid),
  .s_ready       (s_ready),
  .tool_blank    (tool_blank),
  .cfg_mode      (cfg_mode),
  .cfg_target    (cfg_target),
  .beam_blank    (beam_blank),
  .est_pulses    (est_pulses),
  .est_electrons (est_electrons)
);

// File: tb/ecount_dose_ctrl_test.sv
`timescale 1ns/1ps
module ecount_dose_ctrl_test;

  localparam int SW = 8;
  localparam int AW = 12;
  localparam int RW = 8;
  localparam int FW = 8;
  localparam int CW = 6;
  localparam int NVEC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [SW-1:0] s_data = '0;
  logic          tool_blank = 1'b0;
  logic [1:0]    cfg_mode = 2'b01;
  logic [SW-1:0] cfg_thr_hi = 8'd100;
  logic [SW-1:0] cfg_thr_lo = 8'd40;
  logic [RW-1:0] cfg_recip = 8'd2;
  logic [CW-1:0] cfg_target = 6'd3;
  logic          beam_blank;
  logic [CW-1:0] est_pulses;
  logic [CW-1:0] est_electrons;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  ecount_dose_ctrl #(
    .SAMPLE_W (SW),
    .AREA_W   (AW),
    .RECIP_W  (RW),
    .FRAC_W   (FW),
    .COUNT_W  (CW)
  ) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .s_valid       (s_valid),
    .s_ready       (s_ready),
    .s_data        (s_data),
    .tool_blank    (tool_blank),
    .cfg_mode      (cfg_mode),
    .cfg_thr_hi    (cfg_thr_hi),
    .cfg_thr_lo    (cfg_thr_lo),
    .cfg_recip     (cfg_recip),
    .cfg_target    (cfg_target),
    .beam_blank    (beam_blank),
    .est_pulses    (est_pulses),
    .est_electrons (est_electrons)
  );

  // {tool_blank, valid, data, expected pulses, expected electrons, expected blank}
  // mode area, target 3, high 100, low 40, reciprocal 2/256
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 8'd200, 6'd0, 6'd0, 1'b1},
    {1'b0, 1'b1, 8'd50,  6'd0, 6'd0, 1'b0},
    {1'b0, 1'b1, 8'd100, 6'd0, 6'd0, 1'b0},
    {1'b0, 1'b1, 8'd120, 6'd1, 6'd0, 1'b0},
    {1'b0, 1'b0, 8'd10,  6'd1, 6'd0, 1'b0},
    {1'b0, 1'b1, 8'd130, 6'd1, 6'd0, 1'b0},
    {1'b0, 1'b1, 8'd60,  6'd1, 6'd0, 1'b0},
    {1'b0, 1'b1, 8'd39,  6'd1, 6'd2, 1'b0},
    {1'b0, 1'b1, 8'd150, 6'd2, 6'd2, 1'b0},
    {1'b0, 1'b1, 8'd20,  6'd2, 6'd3, 1'b1},
    {1'b0, 1'b1, 8'd200, 6'd3, 6'd3, 1'b1},
    {1'b0, 1'b1, 8'd0,   6'd3, 6'd5, 1'b1},
    {1'b1, 1'b1, 8'd0,   6'd0, 6'd0, 1'b1},
    {1'b0, 1'b1, 8'd110, 6'd1, 6'd0, 1'b0},
    {1'b0, 1'b1, 8'd10,  6'd1, 6'd0, 1'b0},
    {1'b0, 1'b1, 8'd10,  6'd1, 6'd0, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic blank, input logic vld, input logic [SW-1:0] d);
    @(negedge clk);
    tool_blank = blank;
    s_valid    = vld;
    s_data     = d;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R11 / R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R11 pulses in reset", int'(est_pulses), 0);
    chk("R11 electrons in reset", int'(est_electrons), 0);
    chk("R1 ready in reset", int'(s_ready), 1);
    chk("R7 no blank in reset without tool blank", int'(beam_blank), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table: R2 R4 R5 R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][22], VEC[i][21], VEC[i][20:13]);
      chk($sformatf("R2/R3 pulses row %0d", i), int'(est_pulses), int'(VEC[i][12:7]));
      chk($sformatf("R4/R5 electrons row %0d", i), int'(est_electrons), int'(VEC[i][6:1]));
      chk($sformatf("R7 blank row %0d", i), int'(beam_blank), int'(VEC[i][0]));
    end
    chk("R1 ready after table", int'(s_ready), 1);

    // R6 / R3 pulse mode, target 2
    @(negedge clk);
    cfg_mode = 2'b00;
    cfg_target = 6'd2;
    step(1'b1, 1'b0, 8'd0);
    step(1'b0, 1'b1, 8'd120);
    chk("R3 first pulse counted on open", int'(est_pulses), 1);
    step(1'b0, 1'b1, 8'd10);
    chk("R6 pulse mode below target", int'(beam_blank), 0);
    step(1'b0, 1'b1, 8'd120);
    chk("R3 second pulse", int'(est_pulses), 2);
    chk("R6 pulse mode blanks at target", int'(beam_blank), 1);
    step(1'b0, 1'b1, 8'd10);
    chk("R9 area still counted after target", int'(est_electrons), 1);

    // R6 first-of-two mode, area reaches target first
    @(negedge clk);
    cfg_mode = 2'b10;
    step(1'b1, 1'b0, 8'd0);
    step(1'b0, 1'b1, 8'd255);
    step(1'b0, 1'b1, 8'd255);
    step(1'b0, 1'b1, 8'd10);
    chk("R4 electrons from 510 area", int'(est_electrons), 3);
    chk("R6 pulses one", int'(est_pulses), 1);
    chk("R6 first-of-two blanks on area", int'(beam_blank), 1);
    @(negedge clk);
    cfg_mode = 2'b00;
    #1;
    chk("R6 pulse mode ignores area estimate", int'(beam_blank), 0);
    @(negedge clk);
    cfg_mode = 2'b11;
    #1;
    chk("R6 mode 3 also first-of-two", int'(beam_blank), 1);

    // R8 blank cuts an open pulse
    @(negedge clk);
    cfg_mode = 2'b01;
    cfg_target = 6'd5;
    step(1'b1, 1'b0, 8'd0);
    step(1'b0, 1'b1, 8'd200);
    chk("R8 pulse opened", int'(est_pulses), 1);
    step(1'b1, 1'b1, 8'd200);
    chk("R8 blank clears pulses", int'(est_pulses), 0);
    step(1'b0, 1'b1, 8'd10);
    chk("R8 cut pulse not closed", int'(est_electrons), 0);
    chk("R8 no pulse reopened", int'(est_pulses), 0);
    chk("R7 released below target", int'(beam_blank), 0);

    // R7 zero target
    @(negedge clk);
    cfg_target = 6'd0;
    step(1'b1, 1'b0, 8'd0);
    step(1'b0, 1'b0, 8'd0);
    chk("R7 zero target keeps blank", int'(beam_blank), 1);

    // R3 / R4 saturation
    @(negedge clk);
    cfg_mode = 2'b00;
    cfg_target = 6'd63;
    step(1'b1, 1'b0, 8'd0);
    for (int k = 0; k < 70; k++) begin
      step(1'b0, 1'b1, 8'd120);
      step(1'b0, 1'b1, 8'd10);
    end
    chk("R3 pulses saturate", int'(est_pulses), 63);
    chk("R4 electrons saturate", int'(est_electrons), 63);
    chk("R7 blank at saturated target", int'(beam_blank), 1);

    step(1'b1, 1'b0, 8'd0);
    chk("R7 tool blank passes", int'(beam_blank), 1);
    finish_run();
  end

endmodule